// File: doc/BRIEF.md
# Shared Address/Data Pin Bus Controller

This block sits between an internal requester and sixteen shared external pins that carry an address in one phase and data in the next. The requester hands over a read or write with a 24-bit address through a valid/ready handshake. The controller then runs the external cycle on the pins and returns a one-cycle completion pulse, with the read data when the access was a read. An external transparent latch, opened by the latch-enable output, keeps the address portion while the pins move on to carry data.

Two data widths are supported. In wide mode all sixteen pins carry data, and the latched address is the low sixteen address bits. In narrow mode only the low eight pins carry data, and the latched address is address bits 23 to 8. The latch phase costs time, so the controller remembers which address portion the external latch currently holds. It skips the latch phase when the next access needs the same portion in the same mode.

The latch-enable polarity can be set, and the port can be switched off so that the pins serve other uses. While it is off, the port issues no bus cycles.

Top module: `mux_bus_port`

## Requirements
- R1: While reset is applied and right after it, rd_n and wr_n are 1, ale is 0 (active high by default), bus_oe is 0, rsp_done is 0, and rsp_rdata is 0.
- R2: req_ready is 1 exactly when the controller is idle and cfg_enable is 1. A request is taken on a clock edge where req_valid and req_ready are both 1.
- R3: An accepted request gets a latch phase unless three conditions all hold: the stored latched portion is valid, it was stored in the current mode, and it equals the new key. The key is req_addr[15:0] when cfg_wide=1 and req_addr[23:8] when cfg_wide=0. Without a latch phase, the data phase starts directly.
- R4: During a latch phase, ale sits at its active level, bus_oe is all ones, bus_out carries the key, and both strobes are 1.
- R5: A latch phase and a data phase each last cfg_len+1 cycles. cfg_len is 0 to 7 and is taken when the request is accepted.
- R6: During a write data phase, wr_n is 0 and rd_n is 1. In wide mode bus_out is req_wdata with bus_oe=16'hFFFF. In narrow mode bus_out is {8'h00, req_wdata[7:0]} with bus_oe=16'h00FF.
- R7: During a read data phase, rd_n is 0, wr_n is 1 and bus_oe is 0. bus_in is sampled on the last cycle of the phase. rsp_rdata becomes bus_in in wide mode and {8'h00, bus_in[7:0]} in narrow mode.
- R8: rsp_done is high for exactly the one cycle after the last data-phase cycle. rsp_rdata holds its value until the next completed read.
- R9: With cfg_ale_low=1, ale rests at 1 and drops to 0 during a latch phase. The polarity is taken only while the controller is idle.
- R10: While cfg_enable is 0 and the controller is idle, no request is taken, rd_n and wr_n stay 1, ale stays at its inactive level, and bus_oe stays 0.
- R11: The first access after a change of cfg_wide always gets a latch phase, even when its key equals the stored one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | 1: port owns the pins; 0: pins left for other use |
| cfg_wide | input | 1 | 1: 16-bit data, 0: 8-bit data |
| cfg_ale_low | input | 1 | 1: latch-enable asserted low |
| cfg_len | input | 3 | Phase length minus one |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| bus_in | input | 16 | Pin input values |
| bus_out | output | 16 | Pin output values |
| bus_oe | output | 16 | Per-pin output enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ale | output | 1 | Address-latch enable at pin level |

## Verification
The assertions check several properties on every cycle. The two strobes are never low together. The pins float whenever the read strobe is low. A latch phase drives every pin with both strobes high. The completion pulse lasts one cycle and always follows a final data cycle. A taken request drops ready at once. An idle, disabled port stays quiet. Other properties only the bench's scenarios can show: whether a latch phase should have been skipped or inserted (same key, changed key, changed mode), the exact phase lengths, the byte lane and zero-fill in narrow mode, and the effect of switching the latch polarity.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
  localparam int ADDR_W   = 24;
  localparam int BUS_W    = 16;
  localparam int NARROW_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // Portion of the address held by the external latch in a given mode.
  function automatic logic [BUS_W-1:0] latch_key(input logic [ADDR_W-1:0] a,
                                                 input logic wide);
    return wide ? a[BUS_W-1:0] : a[ADDR_W-1:ADDR_W-BUS_W];
  endfunction

  // Pins that carry data in a given mode.
  function automatic logic [BUS_W-1:0] data_lanes(input logic wide);
    return wide ? {BUS_W{1'b1}} : {{(BUS_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  endfunction
endpackage

// File: rtl/mbp_tag.sv
module mbp_tag
  import mbp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] key,
  input  logic             wide,
  input  logic             store,
  output logic             hit
);
  logic [BUS_W-1:0] tag_q;
  logic             mode_q;
  logic             valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= '0;
      mode_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (store) begin
      tag_q   <= key;
      mode_q  <= wide;
      valid_q <= 1'b1;
    end
  end

  assign hit = valid_q && (mode_q == wide) && (tag_q == key);
endmodule

// File: rtl/mbp_timer.sv
module mbp_timer #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  output logic             last
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= len;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/mux_bus_port.sv
module mux_bus_port
  import mbp_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_wide,
  input  logic              cfg_ale_low,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_done,
  output logic [BUS_W-1:0]  rsp_rdata,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [BUS_W-1:0]  bus_out,
  output logic [BUS_W-1:0]  bus_oe,
  output logic              rd_n,
  output logic              wr_n,
  output logic              ale
);
  phase_e            state_q, state_d;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  wdata_q;
  logic              write_q;
  logic              wide_q;
  logic              pol_q;
  logic              done_q;
  logic [BUS_W-1:0]  rdata_q;

  // named internal events
  logic             idle;
  logic             accept;
  logic             tag_hit;
  logic             need_latch;
  logic             phase_last;
  logic             addr_last;
  logic             data_last;
  logic             ale_on;
  logic             tmr_load;
  logic [LEN_W-1:0] tmr_len;
  logic [BUS_W-1:0] new_key;

  assign idle       = (state_q == PH_IDLE);
  assign req_ready  = idle && cfg_enable;
  assign accept     = req_valid && req_ready;
  assign new_key    = latch_key(req_addr, cfg_wide);
  assign need_latch = !tag_hit;
  assign addr_last  = (state_q == PH_ADDR) && phase_last;
  assign data_last  = (state_q == PH_DATA) && phase_last;
  assign tmr_load   = accept || addr_last;
  assign tmr_len    = accept ? cfg_len : len_q;

  mbp_tag u_tag (
    .clk   (clk),
    .rst_n (rst_n),
    .key   (new_key),
    .wide  (cfg_wide),
    .store (accept && need_latch),
    .hit   (tag_hit)
  );

  mbp_timer #(.LEN_W(LEN_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .len   (tmr_len),
    .last  (phase_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: if (accept) state_d = need_latch ? PH_ADDR : PH_DATA;
      PH_ADDR: if (phase_last) state_d = PH_DATA;
      PH_DATA: if (phase_last) state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      len_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      wide_q  <= 1'b0;
      pol_q   <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= data_last;
      if (idle) pol_q <= cfg_ale_low;
      if (accept) begin
        len_q   <= cfg_len;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        write_q <= req_write;
        wide_q  <= cfg_wide;
      end
      if (data_last && !write_q) rdata_q <= bus_in & data_lanes(wide_q);
    end
  end

  assign ale_on    = (state_q == PH_ADDR);
  assign ale       = ale_on ^ pol_q;
  assign rd_n      = !((state_q == PH_DATA) && !write_q);
  assign wr_n      = !((state_q == PH_DATA) && write_q);
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;

  always_comb begin
    bus_out = '0;
    bus_oe  = '0;
    if (state_q == PH_ADDR) begin
      bus_out = latch_key(addr_q, wide_q);
      bus_oe  = '1;
    end else if ((state_q == PH_DATA) && write_q) begin
      bus_out = wdata_q & data_lanes(wide_q);
      bus_oe  = data_lanes(wide_q);
    end
  end
endmodule

module mbp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_enable,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rd_n,
  input logic        wr_n,
  input logic        ale_on,
  input logic [15:0] bus_oe,
  input logic        rsp_done,
  input logic        data_last,
  input logic        idle
);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  // R7
  rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (bus_oe == '0));
  // R4
  latch_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_on |-> ((bus_oe == '1) && rd_n && wr_n));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R8
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(data_last));
  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R10
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !cfg_enable) |=> (rd_n && wr_n && !ale_on));
endmodule

bind mux_bus_port mbp_checker i_mbp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_enable (cfg_enable),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .ale_on     (ale_on),
  .bus_oe     (bus_oe),
  .rsp_done   (rsp_done),
  .data_last  (data_last),
  .idle       (idle)
);

// File: tb/test_mux_bus_port.sv
module test_mux_bus_port;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b1, cfg_wide = 1'b1, cfg_ale_low = 1'b0;
  logic [2:0]  cfg_len = 3'd0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] bus_in = '0;
  logic        req_ready, rsp_done, rd_n, wr_n, ale;
  logic [15:0] rsp_rdata, bus_out, bus_oe;

  int total = 0, bad = 0, cyc = 0;

  mux_bus_port i_mux_bus_port (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_wide(cfg_wide),
    .cfg_ale_low(cfg_ale_low), .cfg_len(cfg_len), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .rd_n(rd_n),
    .wr_n(wr_n), .ale(ale));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------- behavioural reference model ----------
  int m_phase = 0, m_elapsed = 0, m_span = 1;
  bit m_pol = 0, m_done = 0, m_wr = 0, m_wide = 0;
  int m_addr = 0, m_wdata = 0, m_rdata = 0;
  bit m_tvalid = 0, m_twide = 0;
  int m_tag = 0;

  function automatic int key_of(input int a, input bit wide);
    return wide ? (a % 65536) : ((a / 256) % 65536);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_pol = 0; m_done = 0; m_rdata = 0; m_tvalid = 0;
    end else begin
      m_done = 0;
      if (m_phase == 0) m_pol = cfg_ale_low;
      if (m_phase == 0) begin
        if (req_valid && cfg_enable) begin
          int k;
          k = key_of(int'(req_addr), cfg_wide);
          m_addr = int'(req_addr); m_wdata = int'(req_wdata);
          m_wr = req_write; m_wide = cfg_wide;
          m_span = int'(cfg_len) + 1; m_elapsed = 0;
          if (m_tvalid && m_twide == cfg_wide && m_tag == k) m_phase = 2;
          else begin
            m_phase = 1; m_tvalid = 1; m_twide = cfg_wide; m_tag = k;
          end
        end
      end else begin
        m_elapsed++;
        if (m_elapsed == m_span) begin
          m_elapsed = 0;
          if (m_phase == 1) m_phase = 2;
          else begin
            m_phase = 0; m_done = 1;
            if (!m_wr) m_rdata = m_wide ? int'(bus_in) : int'(bus_in) % 256;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    #(CLK_P/4);
    begin
      int e_oe, e_out;
      e_oe = 0; e_out = 0;
      if (m_phase == 1) begin e_oe = 65535; e_out = key_of(m_addr, m_wide); end
      else if (m_phase == 2 && m_wr) begin
        e_oe = m_wide ? 65535 : 255;
        e_out = m_wdata % (e_oe + 1);
      end
      check(ale == ((m_phase == 1) ^ m_pol), "R9 ale level", ale, (m_phase == 1) ^ m_pol);
      check(rd_n == !(m_phase == 2 && !m_wr), "R7 rd_n", rd_n, !(m_phase == 2 && !m_wr));
      check(wr_n == !(m_phase == 2 && m_wr), "R6 wr_n", wr_n, !(m_phase == 2 && m_wr));
      check(int'(bus_oe) == e_oe, "R4 bus_oe", bus_oe, e_oe);
      check(int'(bus_out & bus_oe) == e_out, "R6 bus_out", bus_out & bus_oe, e_out);
      check(req_ready == (m_phase == 0 && cfg_enable), "R2 req_ready", req_ready,
            m_phase == 0 && cfg_enable);
      check(rsp_done == m_done, "R8 rsp_done", rsp_done, m_done);
      check(int'(rsp_rdata) == m_rdata, "R7 rsp_rdata", rsp_rdata, m_rdata);
    end
  end

  // ---------- stimulus ----------
  always @(negedge clk) begin
    cyc++;
    bus_in <= 16'hA5C3 ^ 16'(cyc * 16'h0107);
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // exp_latch: 1/0 expected latch phase, -1 not checked here
  task automatic access(input bit wr, input logic [23:0] a, input logic [15:0] d,
                        input logic [2:0] len, input int exp_latch, input string tag);
    int n_ale, n_str, guard;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; cfg_len = len;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    n_ale = 0; n_str = 0; guard = 0;
    while (!rsp_done && guard < 100) begin
      if (ale != cfg_ale_low) n_ale++;
      if (!rd_n || !wr_n) n_str++;
      guard++;
      @(negedge clk);
    end
    check(guard < 100, {tag, " R8 completion seen"}, guard, 0);
    if (exp_latch >= 0)
      check(n_ale == (exp_latch ? int'(len) + 1 : 0), {tag, " R3 latch cycles"},
            n_ale, exp_latch ? int'(len) + 1 : 0);
    check(n_str == int'(len) + 1, {tag, " R5 data cycles"}, n_str, int'(len) + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check(rd_n == 1 && wr_n == 1, "R1 strobes in reset", {rd_n, wr_n}, 3);
    check(ale == 0, "R1 ale in reset", ale, 0);
    check(bus_oe == 0 && rsp_done == 0 && rsp_rdata == 0, "R1 outputs in reset",
          bus_oe, 0);
    rst_n = 1;
    @(negedge clk);
    check(ale == 0 && rd_n && wr_n, "R1 after reset", ale, 0);

    // wide mode
    access(1, 24'h001234, 16'hBEEF, 3'd0, 1, "first write");
    access(0, 24'h001234, 16'h0000, 3'd2, 0, "same key read");
    access(0, 24'h991234, 16'h0000, 3'd1, 0, "upper bits ignored wide");
    access(1, 24'h001235, 16'h1111, 3'd3, 1, "low key changed");
    // R11 mode change forces latch
    @(negedge clk); cfg_wide = 0;
    access(1, 24'h123500, 16'hCD77, 3'd0, 1, "R11 narrow after change");
    access(0, 24'h1235FF, 16'h0000, 3'd2, 0, "narrow same upper");
    access(1, 24'h1236FF, 16'h9A5B, 3'd7, 1, "narrow upper changed");
    @(negedge clk); cfg_wide = 1;
    access(0, 24'h00FF00, 16'h0000, 3'd0, 1, "R11 wide again");

    // R9 polarity
    @(negedge clk); cfg_ale_low = 1;
    @(negedge clk); @(negedge clk);
    check(ale == 1, "R9 idle ale high when active low", ale, 1);
    access(1, 24'h00ABCD, 16'h4242, 3'd1, 1, "R9 low-active latch");
    @(negedge clk); cfg_ale_low = 0;
    @(negedge clk); @(negedge clk);
    check(ale == 0, "R9 idle ale low again", ale, 0);

    // R10 disabled port
    @(negedge clk);
    cfg_enable = 0; req_valid = 1; req_write = 1; req_addr = 24'h000777; cfg_len = 3'd0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check(!req_ready && rd_n && wr_n && ale == 0 && bus_oe == 0,
            "R10 disabled quiet", {req_ready, rd_n, wr_n, ale}, 6);
    end
    req_valid = 0; cfg_enable = 1;
    access(0, 24'h000777, 16'h0000, 3'd1, 1, "R10 after enable");

    // mixed run, model compares every cycle
    for (int i = 0; i < 40; i++) begin
      if (i % 7 == 3) begin @(negedge clk); cfg_wide = ~cfg_wide; end
      access(i[0], {8'(i % 3), 8'(i % 2), 8'(i * 37)}, 16'(i * 16'h1F3D),
             3'(i % 8), -1, "mixed");
    end

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule